// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block arbitrates among a parameterized set of maskable interrupt sources. Every source owns a byte-wide control register. The register holds a 3-bit priority level and a pending flag. Peripherals raise single-cycle request pulses, and the block latches each pulse into the matching pending flag. Software can read each control register over a simple register bus. A write can reprogram the level or drop a pending flag, but a write can never raise one.

The lowest sources are shared slots. For each shared slot, a bit in a separate source-select register decides whether the primary or the alternate peripheral line feeds that slot's flag.

Each cycle the block combines the pending flags and levels with a global enable input and the processor's current priority level. From these it presents the index and level of the single source that may be taken. When the processor acknowledges the source, that source's flag is dropped by hardware.

Top module: `prio_intc`

## Requirements
- R1: After reset every control register reads 0x00, the source-select register reads 0 and `irq_valid` is 0.
- R2: Bus address `i` (i < NSRC) reaches source i's control register. A write stores `bus_wdata[2:0]` as the level. Bits 7:4 of a write are ignored, and they read back as 0. A read returns {4'b0, flag, level[2:0]}, with the flag in bit 3.
- R3: A request pulse on a source's selected line makes its flag 1 from the next clock edge. The flag stays 1 until it is cleared.
- R4: A write with bit 3 = 0 clears the addressed flag. A write with bit 3 = 1 leaves the flag unchanged.
- R5: When a request pulse and a clear arrive in the same cycle, the flag ends up 1. The clear may come from a software write or from an acknowledge.
- R6: A source whose level is 0 is never presented, whatever its flag.
- R7: A pending source can be presented only when `int_enable` is 1 and its level is strictly greater than `cpu_prio`.
- R8: Among presentable sources, the one with the highest level is presented. When levels tie, the lowest index is presented. `irq_level` carries the presented source's level.
- R9: `irq_ack` sampled with `irq_valid` = 1 clears the flag of the presented source at that edge. Other flags are left unchanged.
- R10: Bus address NSRC is the source-select register, with bit s for shared slot s (s < NSHARED). A select bit of 0 routes `req_pri[s]` to the slot and a select bit of 1 routes `req_alt[s]`. The unselected line has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register address (0..NSRC-1 control, NSRC select) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| req_pri | input | NSRC | Primary request pulses, one per source |
| req_alt | input | NSHARED | Alternate request pulses for shared slots |
| int_enable | input | 1 | Global maskable interrupt enable |
| cpu_prio | input | 3 | Current processor priority level |
| irq_valid | output | 1 | A source is presented |
| irq_id | output | IDW | Index of the presented source |
| irq_level | output | 3 | Level of the presented source |
| irq_ack | input | 1 | Processor accepts the presented source |

## Verification
Flag changes from request pulses, software writes and acknowledges all take effect at the first clock edge after the stimulus is presented. The arbitration outputs and the read data are combinational from that registered state, so they are valid right after that edge. The bench drives every input on the falling edge and holds it through exactly one rising edge. It then samples outputs and read data on the following falling edge, one edge after the stimulus. The bench waits three edges after reset release for the internal reset synchronizer before it makes its first check.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] level_t;
  localparam int CTRL_W = 8;
  localparam int FLAG_BIT = 3;
endpackage

// File: rtl/intc_src_reg.sv
module intc_src_reg
  import intc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic [3:0] wdata,
  input  logic       set_in,
  input  logic       ack_clr,
  output level_t     level_q,
  output logic       flag_q
);
  level_t level_d;
  logic   flag_d;
  logic   sw_clr;

  assign sw_clr = wr_hit && !wdata[FLAG_BIT];

  always_comb begin
    level_d = level_q;
    if (wr_hit) level_d = wdata[LVL_W-1:0];
  end

  always_comb begin
    flag_d = flag_q;
    if (sw_clr || ack_clr) flag_d = 1'b0;
    if (set_in)            flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      level_q <= level_d;
      flag_q  <= flag_d;
    end
  end

  // R4
  sw_one_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wdata[FLAG_BIT] && !set_in && !ack_clr) |=> (flag_q == $past(flag_q)));
  // R4
  sw_zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !wdata[FLAG_BIT] && !set_in) |=> !flag_q);
  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_in |=> flag_q);
endmodule

// File: rtl/intc_sel_reg.sv
module intc_sel_reg #(
  parameter int NSHARED = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hit,
  input  logic [NSHARED-1:0] wdata,
  output logic [NSHARED-1:0] sel_q
);
  logic [NSHARED-1:0] sel_d;

  always_comb begin
    sel_d = sel_q;
    if (wr_hit) sel_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  // R10
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(sel_q));
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSRC-1:0]     flags,
  input  level_t [NSRC-1:0]   levels,
  input  logic                int_enable,
  input  level_t              cpu_prio,
  output logic                win_valid,
  output logic [IDW-1:0]      win_id,
  output level_t              win_level
);
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_level = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (int_enable && flags[i] && (levels[i] != '0) && (levels[i] > cpu_prio) &&
          (!win_valid || (levels[i] > win_level))) begin
        win_valid = 1'b1;
        win_id    = IDW'(i);
        win_level = levels[i];
      end
    end
  end

  // R7
  gate_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (int_enable && (win_level > cpu_prio)));
  // R6
  lvl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (win_level != '0));
  // R8
  winner_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (flags[win_id] && (levels[win_id] == win_level)));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int NSRC    = 8,
  parameter int NSHARED = 2,
  localparam int AW  = $clog2(NSRC + 1),
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_addr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic [NSRC-1:0]    req_pri,
  input  logic [NSHARED-1:0] req_alt,
  input  logic               int_enable,
  input  logic [2:0]         cpu_prio,
  output logic               irq_valid,
  output logic [IDW-1:0]     irq_id,
  output logic [2:0]         irq_level,
  input  logic               irq_ack
);
  logic              rst_meta_q, rst_sync_n;
  logic [NSRC-1:0]   flags;
  level_t [NSRC-1:0] levels;
  logic [NSRC-1:0]   src_set;
  logic [NSRC-1:0]   ack_clr;
  logic [NSRC-1:0]   wr_hit;
  logic [NSHARED-1:0] sel_q;
  logic              sel_hit;
  logic              unused_wbits;
  level_t            win_level;

  assign unused_wbits = ^bus_wdata[7:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign sel_hit = bus_wr && (bus_addr == AW'(NSRC));

  intc_sel_reg #(.NSHARED(NSHARED)) u_sel (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_hit (sel_hit),
    .wdata  (bus_wdata[NSHARED-1:0]),
    .sel_q  (sel_q)
  );

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
    if (gi < NSHARED) begin : g_shared
      assign src_set[gi] = sel_q[gi] ? req_alt[gi] : req_pri[gi];
    end else begin : g_plain
      assign src_set[gi] = req_pri[gi];
    end
    assign wr_hit[gi]  = bus_wr && (bus_addr == AW'(gi));
    assign ack_clr[gi] = irq_ack && irq_valid && (irq_id == IDW'(gi));

    intc_src_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_hit  (wr_hit[gi]),
      .wdata   (bus_wdata[3:0]),
      .set_in  (src_set[gi]),
      .ack_clr (ack_clr[gi]),
      .level_q (levels[gi]),
      .flag_q  (flags[gi])
    );
  end

  intc_arbiter #(.NSRC(NSRC)) u_arb (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .flags      (flags),
    .levels     (levels),
    .int_enable (int_enable),
    .cpu_prio   (cpu_prio),
    .win_valid  (irq_valid),
    .win_id     (irq_id),
    .win_level  (win_level)
  );
  assign irq_level = win_level;

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (bus_addr == AW'(i)) bus_rdata = {4'b0000, flags[i], levels[i]};
    end
    if (bus_addr == AW'(NSRC)) bus_rdata[NSHARED-1:0] = sel_q;
  end

  // R9
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_ack && irq_valid && !src_set[irq_id]) |=> !flags[$past(irq_id)]);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_n |-> !irq_valid);
endmodule

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
  localparam int NSRC = 8;
  localparam int NSHARED = 2;
  localparam int AW = $clog2(NSRC + 1);
  localparam int IDW = $clog2(NSRC);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [NSRC-1:0] req_pri = '0;
  logic [NSHARED-1:0] req_alt = '0;
  logic int_enable = 1'b0;
  logic [2:0] cpu_prio = '0;
  logic irq_valid;
  logic [IDW-1:0] irq_id;
  logic [2:0] irq_level;
  logic irq_ack = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  prio_intc #(.NSRC(NSRC), .NSHARED(NSHARED)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_pri(req_pri),
    .req_alt(req_alt), .int_enable(int_enable), .cpu_prio(cpu_prio),
    .irq_valid(irq_valid), .irq_id(irq_id), .irq_level(irq_level),
    .irq_ack(irq_ack)
  );

  // pend[42:35] lvls[34:11] (octal digit k from left = source 7-k)
  // gie[10] cpu[9:7] exp_valid[6] exp_id[5:3] exp_lvl[2:0]
  localparam int NV = 8;
  localparam logic [42:0] VEC [NV] = '{
    {8'h01, 24'o00000003, 1'b1, 3'd0, 1'b1, 3'd0, 3'd3},
    {8'h06, 24'o00000520, 1'b1, 3'd0, 1'b1, 3'd2, 3'd5},
    {8'h0A, 24'o00004040, 1'b1, 3'd0, 1'b1, 3'd1, 3'd4},
    {8'h80, 24'o00000000, 1'b1, 3'd0, 1'b0, 3'd0, 3'd0},
    {8'hFF, 24'o22222222, 1'b1, 3'd2, 1'b0, 3'd0, 3'd0},
    {8'hFF, 24'o22222222, 1'b1, 3'd1, 1'b1, 3'd0, 3'd2},
    {8'h10, 24'o00070000, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0},
    {8'h30, 24'o00760000, 1'b1, 3'd6, 1'b1, 3'd5, 3'd7}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [7:0] data);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [7:0] data);
    bus_addr = AW'(addr);
    #0.5;
    data = bus_rdata;
  endtask

  task automatic pulse(input logic [NSRC-1:0] m, input logic [NSHARED-1:0] a);
    @(negedge clk);
    req_pri = m; req_alt = a;
    @(negedge clk);
    req_pri = '0; req_alt = '0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < NSRC; i++) wr(i, 8'h00);
  endtask

  initial begin
    #400000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < NSRC; i++) begin
      rd(i, d);
      check("R1 ctrl reset", 16'(d), 16'h00);
    end
    rd(NSRC, d);
    check("R1 select reset", 16'(d), 16'h00);
    check("R1 no irq", 16'(irq_valid), 16'h0);

    // Vector table: R6 R7 R8 R3
    for (int v = 0; v < NV; v++) begin
      int_enable = 1'b0;
      for (int i = 0; i < NSRC; i++) wr(i, {5'b0, VEC[v][11 + 3*i +: 3]});
      int_enable = VEC[v][10];
      cpu_prio = VEC[v][9:7];
      pulse(VEC[v][42:35], '0);
      check("R8 vec valid", 16'(irq_valid), 16'(VEC[v][6]));
      if (VEC[v][6]) begin
        check("R8 vec id", 16'(irq_id), 16'(VEC[v][5:3]));
        check("R8 vec level", 16'(irq_level), 16'(VEC[v][2:0]));
      end
    end
    int_enable = 1'b0; cpu_prio = '0;
    clear_all();

    // R2 upper bits ignored, level stored
    wr(4, 8'hF5);
    rd(4, d);
    check("R2 upper bits", 16'(d), 16'h05);
    // R4 writing 1 to flag does not set it
    wr(4, 8'h0D);
    rd(4, d);
    check("R4 write one no set", 16'(d), 16'h05);
    // R3 request sets flag
    pulse(8'h10, '0);
    rd(4, d);
    check("R3 flag set", 16'(d), 16'h0D);
    // R4 writing 1 keeps pending flag
    wr(4, 8'h0D);
    rd(4, d);
    check("R4 write one keeps", 16'(d), 16'h0D);
    // R4 writing 0 clears
    wr(4, 8'h05);
    rd(4, d);
    check("R4 write zero clears", 16'(d), 16'h05);

    // R5 set beats software clear
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(2); bus_wdata = 8'h05; req_pri = 8'h04;
    @(negedge clk);
    bus_wr = 1'b0; req_pri = '0;
    rd(2, d);
    check("R5 set beats write", 16'(d), 16'h0D);
    clear_all();

    // R9 ack clears winner only
    wr(0, 8'h02);
    wr(1, 8'h05);
    int_enable = 1'b1;
    pulse(8'h03, '0);
    check("R9 pre-ack id", 16'(irq_id), 16'h1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    rd(1, d);
    check("R9 winner cleared", 16'(d), 16'h05);
    rd(0, d);
    check("R9 other kept", 16'(d), 16'h0A);
    check("R9 next winner", 16'(irq_id), 16'h0);
    check("R9 next level", 16'(irq_level), 16'h2);

    // R5 set beats ack
    clear_all();
    wr(3, 8'h06);
    pulse(8'h08, '0);
    @(negedge clk); irq_ack = 1'b1; req_pri = 8'h08;
    @(negedge clk); irq_ack = 1'b0; req_pri = '0;
    rd(3, d);
    check("R5 set beats ack", 16'(d), 16'h0E);
    check("R5 still presented", 16'(irq_valid), 16'h1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check("R9 ack drops irq", 16'(irq_valid), 16'h0);
    int_enable = 1'b0;
    clear_all();

    // R10 source select
    pulse('0, 2'b01);
    rd(0, d);
    check("R10 alt ignored when sel=0", 16'(d), 16'h00);
    wr(NSRC, 8'hFD);
    rd(NSRC, d);
    check("R10 select readback", 16'(d), 16'h01);
    pulse(8'h01, '0);
    rd(0, d);
    check("R10 pri ignored when sel=1", 16'(d), 16'h00);
    pulse('0, 2'b01);
    rd(0, d);
    check("R10 alt routed when sel=1", 16'(d), 16'h08);
    pulse(8'h02, '0);
    rd(1, d);
    check("R10 slot1 still primary", 16'(d), 16'h08);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule